// File: doc/BRIEF.md
# DDR2 Bank Timing Legality Gate

This block sits beside a DDR2 command scheduler and answers one question every clock cycle: may the candidate command offered in this cycle be sent to the memory now? The scheduler presents a candidate (command code, bank, and the all-banks flag that address bit 10 carries on a precharge). It also reports through a separate issue strobe the command it actually sent. The gate keeps a small amount of state from those issue reports. For each bank it holds an open flag and elapsed-cycle counts since that bank's last activate and last single-bank precharge. Globally it holds elapsed-cycle counts since the last activate to any bank, the last all-banks precharge and the last refresh.

Same-bank and cross-bank spacing rules are judged together in one verdict: activate-to-activate, activate-to-precharge minimum, activate-to-refresh, precharge-to-activate (single and all-banks windows kept apart), and refresh-to-anything. Two early-warning outputs help the scheduler meet the long-term limits. One per bank says a bank has been open close to the maximum row-active time. The other says the refresh interval is close to running out. Every window is a parameter in picoseconds, turned into cycles by rounding up against a clock-period parameter.

Top module: `dgate_ddr2_bank_gate`

## Requirements
- R1: Command codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4, REF=5; codes 6 and 7 are always illegal, NOP is always legal, and `cand_ok` gives the verdict for the candidate of cycle t in cycle t+1. The verdict uses the state built from issues strictly before cycle t.
- R2: While `init_done` is low, ACT, RD and WR are illegal; PRE and REF are still judged by their timing rules.
- R3: Reset marks every bank open with all elapsed counts saturated, so `force_precharge` is all ones, `refresh_due` is 1 and `cand_ok` is 0 on the cycle after reset.
- R4: ACT is illegal to a bank that is already open, and needs at least the activate-to-activate window (tRRD) since the last ACT to any bank.
- R5: ACT needs at least tRP cycles since that bank's last single-bank PRE, and at least tRPA cycles since the last all-banks PRE.
- R6: A single-bank PRE to an open bank needs at least tRAS-min cycles since that bank's ACT; a PRE to a closed bank is legal. An all-banks PRE needs tRAS-min on every open bank.
- R7: RD and WR are legal only to an open bank.
- R8: REF is legal only with every bank closed and at least tRC cycles since the last ACT.
- R9: For tRFC-min cycles after a REF every command except NOP is illegal.
- R10: `force_precharge[b]` is 1 in the cycle after bank b is open with an activate count at or above the tRAS-max count minus `FORCE_MARGIN`; it is 0 for closed banks.
- R11: `refresh_due` is 1 in the cycle after the refresh count is at or above the tRFC-max count minus `REF_MARGIN`.
- R12: Every elapsed-cycle counter saturates at its all-ones value and never wraps.
- R13: An issued ACT opens its bank. A single-bank PRE closes only its bank and restarts only that bank's precharge count. An all-banks PRE closes every bank and restarts only the global all-banks count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_done | input | 1 | Memory initialization finished; enables ACT/RD/WR |
| cand_cmd | input | 3 | Candidate command code |
| cand_bank | input | BA_W | Candidate bank |
| cand_all | input | 1 | Candidate precharge targets all banks |
| issue_vld | input | 1 | A command was issued this cycle |
| issue_cmd | input | 3 | Issued command code |
| issue_bank | input | BA_W | Issued bank |
| issue_all | input | 1 | Issued precharge targets all banks |
| cand_ok | output | 1 | Registered legality verdict |
| force_precharge | output | 2**BA_W | Per-bank row-open-too-long warning |
| refresh_due | output | 1 | Refresh interval nearly exhausted |

## Verification
Every result is due exactly one rising edge after its cause. The verdict for a candidate held in cycle t appears after the edge that closes cycle t. The warning outputs follow the counter value that the same edge sees. A count restarted by an issue at edge E0 reads k in the cycle after edge E(k-1). The bench drives and samples only on falling edges, and each timing window is probed on both sides of its boundary (one cycle short and exactly met), with the expected cycle worked out from that count. The long windows are walked to their edge and then past the counter's saturation point to expose any wrap.

// File: rtl/dgate_pkg.sv
package dgate_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } cmd_e;

  // Round a window in picoseconds up to whole clock cycles.
  function automatic int ps_to_cyc(input int win_ps, input int clk_ps);
    return (win_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dgate_satcnt.sv
module dgate_satcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  // Reset parks the count at the top: the event is "long ago".
  always_ff @(posedge clk) begin
    if (rst)              cnt <= TOP;
    else if (restart)     cnt <= ONE;
    else if (cnt != TOP)  cnt <= cnt + ONE;
  end

  a_r12_hold_at_top: assert property (@(posedge clk) disable iff (rst)
    (cnt == TOP && !restart) |=> (cnt == TOP));
  a_r12_restart_to_one: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == ONE));
  a_r12_single_step: assert property (@(posedge clk) disable iff (rst)
    (!restart && cnt != TOP) |=> (cnt == $past(cnt) + ONE));

endmodule

// File: rtl/dgate_bank.sv
module dgate_bank #(
  parameter int W          = 15,
  parameter int TRAS_MAX_C = 28000,
  parameter int MARGIN_C   = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         act_hit,
  input  logic         pre_one_hit,
  input  logic         pre_all_hit,
  output logic         open_o,
  output logic [W-1:0] act_cnt,
  output logic [W-1:0] pre_cnt,
  output logic         force_o
);
  localparam int          FTHR   = (TRAS_MAX_C > MARGIN_C) ? TRAS_MAX_C - MARGIN_C : 0;
  localparam logic [W-1:0] FTHR_V = W'(FTHR);

  dgate_satcnt #(.W(W)) u_act_cnt (
    .clk(clk), .rst(rst), .restart(act_hit), .cnt(act_cnt)
  );

  dgate_satcnt #(.W(W)) u_pre_cnt (
    .clk(clk), .rst(rst), .restart(pre_one_hit), .cnt(pre_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst)                             open_o <= 1'b1;
    else if (act_hit)                    open_o <= 1'b1;
    else if (pre_one_hit || pre_all_hit) open_o <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) force_o <= 1'b1;
    else     force_o <= open_o && (act_cnt >= FTHR_V);
  end

  a_r13_act_opens: assert property (@(posedge clk) disable iff (rst)
    act_hit |=> open_o);
  a_r13_pre_closes: assert property (@(posedge clk) disable iff (rst)
    (pre_one_hit || pre_all_hit) |=> !open_o);
  a_r10_closed_no_force: assert property (@(posedge clk) disable iff (rst)
    !open_o |=> !force_o);

endmodule

// File: rtl/dgate_rules.sv
module dgate_rules
  import dgate_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int W      = 15,
  parameter int TRRD_C = 4,
  parameter int TRAS_C = 16,
  parameter int TRC_C  = 22,
  parameter int TRP_C  = 6,
  parameter int TRPA_C = 6,
  parameter int TRFC_C = 42
) (
  input  logic [2:0]              cmd,
  input  logic [BA_W-1:0]         bank,
  input  logic                    all_banks,
  input  logic                    init_done,
  input  logic [(1<<BA_W)-1:0]    open_v,
  input  logic [(1<<BA_W)*W-1:0]  act_cnts,
  input  logic [(1<<BA_W)*W-1:0]  pre_cnts,
  input  logic [W-1:0]            g_act,
  input  logic [W-1:0]            g_prea,
  input  logic [W-1:0]            ref_cnt,
  output logic                    ok
);
  localparam int NB = 1 << BA_W;
  localparam logic [W-1:0] TRRD_V = W'(TRRD_C);
  localparam logic [W-1:0] TRAS_V = W'(TRAS_C);
  localparam logic [W-1:0] TRC_V  = W'(TRC_C);
  localparam logic [W-1:0] TRP_V  = W'(TRP_C);
  localparam logic [W-1:0] TRPA_V = W'(TRPA_C);
  localparam logic [W-1:0] TRFC_V = W'(TRFC_C);

  logic [NB-1:0] tras_met;
  logic [W-1:0]  pre_sel;
  logic          rfc_met;
  logic          all_tras;
  logic          sel_open;

  for (genvar i = 0; i < NB; i++) begin : g_tras
    assign tras_met[i] = act_cnts[i*W +: W] >= TRAS_V;
  end

  always_comb begin
    pre_sel  = pre_cnts[bank*W +: W];
    sel_open = open_v[bank];
    rfc_met  = ref_cnt >= TRFC_V;
    all_tras = &(tras_met | ~open_v);
  end

  always_comb begin
    ok = 1'b0;
    case (cmd_e'(cmd))
      CMD_NOP: ok = 1'b1;
      CMD_ACT: ok = init_done && rfc_met && !sel_open &&
                    (g_act >= TRRD_V) && (pre_sel >= TRP_V) && (g_prea >= TRPA_V);
      CMD_RD,
      CMD_WR:  ok = init_done && rfc_met && sel_open;
      CMD_PRE: ok = rfc_met && (all_banks ? all_tras : (!sel_open || tras_met[bank]));
      CMD_REF: ok = rfc_met && (open_v == '0) && (g_act >= TRC_V);
      default: ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/dgate_ddr2_bank_gate.sv
module dgate_ddr2_bank_gate
  import dgate_pkg::*;
#(
  parameter int BA_W         = 2,
  parameter int CLK_PS       = 2500,
  parameter int TRRD_PS      = 10000,
  parameter int TRAS_PS      = 40000,
  parameter int TRAS_MAX_PS  = 70000000,
  parameter int TRC_PS       = 54000,
  parameter int TRP_PS       = 13125,
  parameter int TRPA_PS      = 13125,
  parameter int TRFC_PS      = 105000,
  parameter int TRFC_MAX_PS  = 70000000,
  parameter int FORCE_MARGIN = 64,
  parameter int REF_MARGIN   = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  init_done,
  input  logic [2:0]            cand_cmd,
  input  logic [BA_W-1:0]       cand_bank,
  input  logic                  cand_all,
  input  logic                  issue_vld,
  input  logic [2:0]            issue_cmd,
  input  logic [BA_W-1:0]       issue_bank,
  input  logic                  issue_all,
  output logic                  cand_ok,
  output logic [(1<<BA_W)-1:0]  force_precharge,
  output logic                  refresh_due
);
  localparam int NB         = 1 << BA_W;
  localparam int TRRD_C     = ps_to_cyc(TRRD_PS, CLK_PS);
  localparam int TRAS_C     = ps_to_cyc(TRAS_PS, CLK_PS);
  localparam int TRAS_MAX_C = ps_to_cyc(TRAS_MAX_PS, CLK_PS);
  localparam int TRC_C      = ps_to_cyc(TRC_PS, CLK_PS);
  localparam int TRP_C      = ps_to_cyc(TRP_PS, CLK_PS);
  localparam int TRPA_C     = ps_to_cyc(TRPA_PS, CLK_PS);
  localparam int TRFC_C     = ps_to_cyc(TRFC_PS, CLK_PS);
  localparam int TRFC_MAX_C = ps_to_cyc(TRFC_MAX_PS, CLK_PS);
  localparam int MAXC       = imax(imax(TRAS_MAX_C, TRFC_MAX_C), imax(TRC_C, TRFC_C));
  localparam int W          = $clog2(MAXC + 1);
  localparam int REF_THR    = (TRFC_MAX_C > REF_MARGIN) ? TRFC_MAX_C - REF_MARGIN : 0;
  localparam logic [W-1:0] REF_THR_V = W'(REF_THR);

  logic          is_act, is_pre, is_ref, pre_all;
  logic [NB-1:0] open_v;
  logic [NB*W-1:0] act_cnts, pre_cnts;
  logic [W-1:0]  g_act, g_prea, ref_cnt;
  logic          ok_c;

  always_comb begin
    is_act  = issue_vld && (cmd_e'(issue_cmd) == CMD_ACT);
    is_pre  = issue_vld && (cmd_e'(issue_cmd) == CMD_PRE);
    is_ref  = issue_vld && (cmd_e'(issue_cmd) == CMD_REF);
    pre_all = is_pre && issue_all;
  end

  for (genvar i = 0; i < NB; i++) begin : g_bank
    logic sel;
    assign sel = (issue_bank == BA_W'(i));
    dgate_bank #(
      .W(W), .TRAS_MAX_C(TRAS_MAX_C), .MARGIN_C(FORCE_MARGIN)
    ) u_bank (
      .clk         (clk),
      .rst         (rst),
      .act_hit     (is_act && sel),
      .pre_one_hit (is_pre && !issue_all && sel),
      .pre_all_hit (pre_all),
      .open_o      (open_v[i]),
      .act_cnt     (act_cnts[i*W +: W]),
      .pre_cnt     (pre_cnts[i*W +: W]),
      .force_o     (force_precharge[i])
    );
  end

  dgate_satcnt #(.W(W)) u_gact  (.clk(clk), .rst(rst), .restart(is_act),  .cnt(g_act));
  dgate_satcnt #(.W(W)) u_gprea (.clk(clk), .rst(rst), .restart(pre_all), .cnt(g_prea));
  dgate_satcnt #(.W(W)) u_gref  (.clk(clk), .rst(rst), .restart(is_ref),  .cnt(ref_cnt));

  dgate_rules #(
    .BA_W(BA_W), .W(W), .TRRD_C(TRRD_C), .TRAS_C(TRAS_C), .TRC_C(TRC_C),
    .TRP_C(TRP_C), .TRPA_C(TRPA_C), .TRFC_C(TRFC_C)
  ) u_rules (
    .cmd       (cand_cmd),
    .bank      (cand_bank),
    .all_banks (cand_all),
    .init_done (init_done),
    .open_v    (open_v),
    .act_cnts  (act_cnts),
    .pre_cnts  (pre_cnts),
    .g_act     (g_act),
    .g_prea    (g_prea),
    .ref_cnt   (ref_cnt),
    .ok        (ok_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_ok     <= 1'b0;
      refresh_due <= 1'b1;
    end else begin
      cand_ok     <= ok_c;
      refresh_due <= ref_cnt >= REF_THR_V;
    end
  end

  a_r1_nop_legal: assert property (@(posedge clk) disable iff (rst)
    (cand_cmd == 3'd0) |=> cand_ok);
  a_r2_init_blocks: assert property (@(posedge clk) disable iff (rst)
    (!init_done && (cand_cmd == 3'd1 || cand_cmd == 3'd2 || cand_cmd == 3'd3)) |=> !cand_ok);
  a_r9_refresh_quiet: assert property (@(posedge clk) disable iff (rst)
    (TRFC_C > 1 && issue_vld && issue_cmd == 3'd5) ##1 (cand_cmd != 3'd0) |=> !cand_ok);
  a_r11_due_clears: assert property (@(posedge clk) disable iff (rst)
    (REF_THR > 1 && issue_vld && issue_cmd == 3'd5) |=> ##1 !refresh_due);

endmodule

// File: tb/dgate_ddr2_bank_gate_tb.sv
module dgate_ddr2_bank_gate_tb;

  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_REF = 3'd5, C_BAD = 3'd6;
  // DUT timed for a 5000 ps cycle: tRRD 2, tRAS 8, tRC 11, tRP 3, tRPA 3,
  // tRFC 21, long limits 14000, margins 32.
  localparam int THR = 14000 - 32;

  logic       clk = 1'b0;
  logic       rst, init_done;
  logic [2:0] cand_cmd, issue_cmd;
  logic [1:0] cand_bank, issue_bank;
  logic       cand_all, issue_all, issue_vld;
  logic       cand_ok;
  logic [3:0] force_precharge;
  logic       refresh_due;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 20 ns period, 50 MHz

  dgate_ddr2_bank_gate #(
    .BA_W(2), .CLK_PS(5000), .FORCE_MARGIN(32), .REF_MARGIN(32)
  ) u_dut (
    .clk(clk), .rst(rst), .init_done(init_done),
    .cand_cmd(cand_cmd), .cand_bank(cand_bank), .cand_all(cand_all),
    .issue_vld(issue_vld), .issue_cmd(issue_cmd), .issue_bank(issue_bank),
    .issue_all(issue_all),
    .cand_ok(cand_ok), .force_precharge(force_precharge), .refresh_due(refresh_due)
  );

  typedef struct packed {
    logic [7:0] rep;
    logic       iv;
    logic [2:0] ic;
    logic [1:0] ib;
    logic       ia;
    logic [2:0] cc;
    logic [1:0] cb;
    logic       ca;
    logic       ex;
    logic [3:0] rq;
  } row_t;

  localparam int NROW = 26;
  localparam row_t TAB [NROW] = '{
    '{8'd1,  1'b1, C_PRE, 2'd0, 1'b1, C_RD,  2'd2, 1'b0, 1'b1, 4'd7},  // R7 open after reset; R13 all-close issued
    '{8'd2,  1'b0, C_NOP, 2'd0, 1'b0, C_ACT, 2'd0, 1'b0, 1'b0, 4'd5},  // R5 tRPA count 2
    '{8'd1,  1'b1, C_ACT, 2'd0, 1'b0, C_ACT, 2'd0, 1'b0, 1'b1, 4'd5},  // R5 tRPA count 3 met
    '{8'd1,  1'b0, C_NOP, 2'd0, 1'b0, C_ACT, 2'd1, 1'b0, 1'b0, 4'd4},  // R4 tRRD count 1
    '{8'd1,  1'b1, C_ACT, 2'd1, 1'b0, C_ACT, 2'd1, 1'b0, 1'b1, 4'd4},  // R4 tRRD count 2 met
    '{8'd1,  1'b0, C_NOP, 2'd0, 1'b0, C_ACT, 2'd0, 1'b0, 1'b0, 4'd4},  // R4 bank already open
    '{8'd1,  1'b0, C_NOP, 2'd0, 1'b0, C_WR,  2'd1, 1'b0, 1'b1, 4'd7},  // R7 write to open bank
    '{8'd3,  1'b0, C_NOP, 2'd0, 1'b0, C_PRE, 2'd0, 1'b0, 1'b0, 4'd6},  // R6 tRAS count 7
    '{8'd1,  1'b1, C_PRE, 2'd0, 1'b0, C_PRE, 2'd0, 1'b0, 1'b1, 4'd6},  // R6 tRAS count 8 met
    '{8'd1,  1'b0, C_NOP, 2'd0, 1'b0, C_PRE, 2'd0, 1'b1, 1'b0, 4'd6},  // R6 all-banks, bank1 at 7
    '{8'd1,  1'b0, C_NOP, 2'd0, 1'b0, C_ACT, 2'd0, 1'b0, 1'b0, 4'd5},  // R5 tRP count 2
    '{8'd1,  1'b0, C_NOP, 2'd0, 1'b0, C_ACT, 2'd0, 1'b0, 1'b1, 4'd5},  // R5 tRP count 3 met
    '{8'd1,  1'b0, C_NOP, 2'd0, 1'b0, C_PRE, 2'd0, 1'b1, 1'b1, 4'd6},  // R6 all-banks, bank1 at 10
    '{8'd1,  1'b0, C_NOP, 2'd0, 1'b0, C_REF, 2'd0, 1'b0, 1'b0, 4'd13}, // R13 bank1 still open after single PRE
    '{8'd1,  1'b1, C_PRE, 2'd1, 1'b0, C_REF, 2'd0, 1'b0, 1'b0, 4'd8},  // R8 bank open
    '{8'd1,  1'b1, C_REF, 2'd0, 1'b0, C_REF, 2'd0, 1'b0, 1'b1, 4'd8},  // R8 all closed, tRC met
    '{8'd19, 1'b0, C_NOP, 2'd0, 1'b0, C_NOP, 2'd0, 1'b0, 1'b1, 4'd9},  // R9 NOP allowed in tRFC
    '{8'd1,  1'b0, C_NOP, 2'd0, 1'b0, C_PRE, 2'd2, 1'b0, 1'b0, 4'd9},  // R9 count 20
    '{8'd1,  1'b0, C_NOP, 2'd0, 1'b0, C_PRE, 2'd2, 1'b0, 1'b1, 4'd9},  // R9 count 21 met
    '{8'd1,  1'b1, C_ACT, 2'd2, 1'b0, C_ACT, 2'd2, 1'b0, 1'b1, 4'd5},  // R5 untouched bank timer
    '{8'd7,  1'b0, C_NOP, 2'd0, 1'b0, C_PRE, 2'd2, 1'b0, 1'b0, 4'd6},  // R6 tRAS count 7
    '{8'd1,  1'b1, C_PRE, 2'd2, 1'b0, C_PRE, 2'd2, 1'b0, 1'b1, 4'd6},  // R6 count 8 met
    '{8'd2,  1'b0, C_NOP, 2'd0, 1'b0, C_REF, 2'd0, 1'b0, 1'b0, 4'd8},  // R8 tRC count 10
    '{8'd1,  1'b0, C_NOP, 2'd0, 1'b0, C_REF, 2'd0, 1'b0, 1'b1, 4'd8},  // R8 tRC count 11 met
    '{8'd1,  1'b0, C_NOP, 2'd0, 1'b0, C_BAD, 2'd0, 1'b0, 1'b0, 4'd1},  // R1 unused code
    '{8'd1,  1'b0, C_NOP, 2'd0, 1'b0, C_RD,  2'd1, 1'b0, 1'b0, 4'd7}   // R7 read to closed bank
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic set_cand(input logic [2:0] c, input logic [1:0] b, input logic a);
    cand_cmd  = c;
    cand_bank = b;
    cand_all  = a;
  endtask

  task automatic do_issue(input logic [2:0] c, input logic [1:0] b, input logic a);
    issue_vld  = 1'b1;
    issue_cmd  = c;
    issue_bank = b;
    issue_all  = a;
    tick(1);
    issue_vld  = 1'b0;
  endtask

  initial begin
    rst = 1'b1; init_done = 1'b0;
    issue_vld = 1'b0; issue_cmd = C_NOP; issue_bank = 2'd0; issue_all = 1'b0;
    set_cand(C_NOP, 2'd0, 1'b0);
    tick(3);
    chk("R3 reset force_precharge", 32'(force_precharge), 32'hF);
    chk("R3 reset refresh_due", 32'(refresh_due), 32'h1);
    chk("R3 reset cand_ok", 32'(cand_ok), 32'h0);
    rst = 1'b0;
    tick(1);
    chk("R1 NOP legal", 32'(cand_ok), 32'h1);
    set_cand(C_RD, 2'd0, 1'b0);
    tick(1);
    chk("R2 read before init", 32'(cand_ok), 32'h0);
    set_cand(C_PRE, 2'd0, 1'b1);
    tick(1);
    chk("R2 R3 precharge-all before init", 32'(cand_ok), 32'h1);
    init_done = 1'b1;
    set_cand(C_RD, 2'd0, 1'b0);
    tick(1);
    chk("R3 R7 bank open after reset", 32'(cand_ok), 32'h1);

    for (int r = 0; r < NROW; r++) begin
      set_cand(TAB[r].cc, TAB[r].cb, TAB[r].ca);
      issue_vld  = TAB[r].iv;
      issue_cmd  = TAB[r].ic;
      issue_bank = TAB[r].ib;
      issue_all  = TAB[r].ia;
      tick(1);
      issue_vld = 1'b0;
      if (TAB[r].rep > 8'd1) tick(int'(TAB[r].rep) - 1);
      chk($sformatf("R%0d table row %0d", TAB[r].rq, r), 32'(cand_ok), 32'(TAB[r].ex));
    end

    // R10 warning window on bank 3
    set_cand(C_NOP, 2'd0, 1'b0);
    chk("R10 closed banks quiet", 32'(force_precharge), 32'h0);
    do_issue(C_ACT, 2'd3, 1'b0);
    tick(THR - 1);
    chk("R10 one cycle before margin", 32'(force_precharge), 32'h0);
    tick(1);
    chk("R10 margin reached", 32'(force_precharge), 32'h8);
    tick(3000);
    chk("R12 activate count held past top", 32'(force_precharge), 32'h8);
    set_cand(C_PRE, 2'd3, 1'b0);
    tick(1);
    chk("R12 precharge still legal", 32'(cand_ok), 32'h1);
    set_cand(C_NOP, 2'd0, 1'b0);
    do_issue(C_PRE, 2'd3, 1'b0);
    tick(1);
    chk("R10 cleared after close", 32'(force_precharge), 32'h0);

    // R11 refresh warning
    chk("R11 overdue refresh", 32'(refresh_due), 32'h1);
    do_issue(C_REF, 2'd0, 1'b0);
    tick(1);
    chk("R11 cleared after refresh", 32'(refresh_due), 32'h0);
    tick(THR - 2);
    chk("R11 one cycle before margin", 32'(refresh_due), 32'h0);
    tick(1);
    chk("R11 margin reached", 32'(refresh_due), 32'h1);

    // R3 reset in mid-run
    do_issue(C_ACT, 2'd1, 1'b0);
    rst = 1'b1;
    tick(1);
    chk("R3 mid-run reset force_precharge", 32'(force_precharge), 32'hF);
    chk("R3 mid-run reset refresh_due", 32'(refresh_due), 32'h1);
    chk("R3 mid-run reset cand_ok", 32'(cand_ok), 32'h0);
    rst = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule